// File: doc/BRIEF.md
# UART Interrupt Identifier

This block decides which of a UART's interrupt causes is reported to the host, and drives the interrupt request line. It watches the receive-error flags, the receive queue occupancy, the idle-time counter kept by the receiver, and the transmit-holding-register empty status. It also sees the host's read and write strobes to the identification, line-status, receive-buffer and transmit-holding registers. From these it keeps one pending flag per cause and applies each cause's own clearing rule. It then picks the most urgent enabled cause and presents the matching identification byte.

The identification byte always carries the queue-enabled marker 0xC in its upper nibble. Its lower nibble holds the cause code, and bit 0 of that code is 1 when nothing is pending. Pending flags are registered, so a cause that arises in a cycle is reported from the following clock edge on. The enable mask acts on the output at once and never erases a pending flag.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, and whenever no enabled cause is pending, the identification byte is 0xC1 and irq is low.
- R2: A 0-to-1 change of any bit of lineErr sets the line-status cause, reported as 0xC6 when ierEn[2] is 1. A pulse on lsrRead clears it unless a new error bit rises in the same cycle.
- R3: When ierEn[0] is 1 and, at the previous clock edge, rxCount was at or above the selected trigger level, the byte reads 0xC4. The cause drops at the first edge where rxCount is below the level.
- R4: trigSel values 0, 1, 2 and 3 select trigger levels of 1, 4, 8 and 14 characters.
- R5: With rxCount non-zero and idleChars at least 4, the timeout cause is set and reported as 0xCC when ierEn[0] is 1. It is cleared by an rbrRead pulse, and also whenever rxCount is 0.
- R6: The transmit-empty cause is set when txEmpty rises, or when ierEn[1] rises while txEmpty is 1. It is reported as 0xC2 when ierEn[1] is 1, and it is cleared by a thrWrite pulse or by txEmpty going low.
- R7: An iirRead pulse clears the transmit-empty cause only when the byte shows 0xC2 in that cycle. Otherwise it leaves every cause untouched.
- R8: irq is high exactly when bit 0 of the identification byte is 0.
- R9: With ierEn at 0 the byte reads 0xC1 and irq is low in the same cycle. Pending causes are kept, and they reappear when the enables are set again.
- R10: Priority from highest to lowest is line status (0xC6), data available (0xC4), timeout (0xCC), transmit empty (0xC2). Exactly one code is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ierEn | input | 3 | Enables: bit 0 receive data and timeout, bit 1 transmit empty, bit 2 line status |
| lineErr | input | ERR_W | Receive error flags (overrun, parity, framing, break) |
| rxCount | input | CNT_W | Characters held in the receive queue |
| trigSel | input | 2 | Receive trigger level select |
| idleChars | input | TO_W | Character times since the last receive-queue activity |
| txEmpty | input | 1 | Transmit holding register is empty |
| iirRead | input | 1 | One-cycle strobe: host reads the identification byte |
| lsrRead | input | 1 | One-cycle strobe: host reads line status |
| rbrRead | input | 1 | One-cycle strobe: host reads the receive buffer |
| thrWrite | input | 1 | One-cycle strobe: host writes the transmit holding register |
| iirValue | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions assume that every host strobe is a synchronous pulse lasting exactly one cycle. They also assume that rxCount never exceeds the queue depth, and that idleChars is kept by the receiver, which zeroes it on buffer reads. The directed phase drives each strobe for exactly one clock and keeps rxCount within 0 to 16. The random phase draws strobes independently for each cycle and caps rxCount and idleChars at their legal maxima. In that phase it produces overlaps such as a line-status read colliding with a freshly rising error bit, and an identification read landing while a higher cause is shown.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  // Lower nibble of the identification byte, one code per cause.
  typedef enum logic [3:0] {
    ID_NONE    = 4'b0001,
    ID_LINE    = 4'b0110,
    ID_RDA     = 4'b0100,
    ID_TIMEOUT = 4'b1100,
    ID_THRE    = 4'b0010
  } irqId_t;

  // Strobes sent from the control to the pending-state datapath.
  typedef struct packed {
    logic setLine;
    logic clrLine;
    logic clrTimeout;
    logic setThre;
    logic clrThre;
  } irqStrobes_t;

  localparam logic [3:0] IIR_FIFO_MARK = 4'hC;

endpackage

// File: rtl/uart_irq_ctrl.sv
`timescale 1ns/1ps
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] lineErr,
  input  logic             txEmpty,
  input  logic             threEnable,
  input  logic             iirRead,
  input  logic             lsrRead,
  input  logic             rbrRead,
  input  logic             thrWrite,
  input  irqId_t           shownId,
  output irqStrobes_t      strobes
);

  logic [ERR_W-1:0] errPrev;
  logic             txPrev;
  logic             threEnPrev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      errPrev    <= '0;
      txPrev     <= 1'b0;
      threEnPrev <= 1'b0;
    end else begin
      errPrev    <= lineErr;
      txPrev     <= txEmpty;
      threEnPrev <= threEnable;
    end
  end

  logic newErr;
  logic txRise;
  logic enRise;
  logic threShown;

  always_comb begin
    newErr    = |(lineErr & ~errPrev);
    txRise    = txEmpty & ~txPrev;
    enRise    = threEnable & ~threEnPrev;
    threShown = (shownId == ID_THRE);

    strobes.setLine    = newErr;
    strobes.clrLine    = lsrRead;
    strobes.clrTimeout = rbrRead;
    strobes.setThre    = txRise | (txEmpty & enRise);
    strobes.clrThre    = thrWrite | ~txEmpty | (iirRead & threShown);
  end

  // R7: an identification read with another code shown must not clear the transmit-empty cause
  assert_iir_read_scope_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iirRead && !threShown && !thrWrite && txEmpty) |-> !strobes.clrThre);

endmodule

// File: rtl/uart_irq_dpath.sv
`timescale 1ns/1ps
module uart_irq_dpath
  import uart_irq_pkg::*;
#(
  parameter int CNT_W         = 5,
  parameter int TO_W          = 4,
  parameter int TIMEOUT_CHARS = 4,
  parameter int TRIG_L0       = 1,
  parameter int TRIG_L1       = 4,
  parameter int TRIG_L2       = 8,
  parameter int TRIG_L3       = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irqStrobes_t      strobes,
  input  logic [2:0]       ierEn,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [1:0]       trigSel,
  input  logic [TO_W-1:0]  idleChars,
  output irqId_t           shownId,
  output logic [7:0]       iirValue
);

  localparam logic [CNT_W-1:0] LVL0     = CNT_W'(TRIG_L0);
  localparam logic [CNT_W-1:0] LVL1     = CNT_W'(TRIG_L1);
  localparam logic [CNT_W-1:0] LVL2     = CNT_W'(TRIG_L2);
  localparam logic [CNT_W-1:0] LVL3     = CNT_W'(TRIG_L3);
  localparam logic [TO_W-1:0]  IDLE_LIM = TO_W'(TIMEOUT_CHARS);

  logic [CNT_W-1:0] trigLevel;
  logic             aboveLevel;
  logic             fifoHasData;
  logic             idleHit;

  always_comb begin
    unique case (trigSel)
      2'd0:    trigLevel = LVL0;
      2'd1:    trigLevel = LVL1;
      2'd2:    trigLevel = LVL2;
      default: trigLevel = LVL3;
    endcase
    aboveLevel  = (rxCount >= trigLevel);
    fifoHasData = (rxCount != '0);
    idleHit     = (idleChars >= IDLE_LIM);
  end

  logic linePend;
  logic rdaPend;
  logic toPend;
  logic threPend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      linePend <= 1'b0;
      rdaPend  <= 1'b0;
      toPend   <= 1'b0;
      threPend <= 1'b0;
    end else begin
      linePend <= strobes.setLine | (linePend & ~strobes.clrLine);
      rdaPend  <= aboveLevel;
      toPend   <= fifoHasData & ~strobes.clrTimeout & (toPend | idleHit);
      threPend <= ~strobes.clrThre & (threPend | strobes.setThre);
    end
  end

  logic selLine;
  logic selRda;
  logic selTo;
  logic selThre;

  always_comb begin
    selLine = linePend & ierEn[2];
    selRda  = rdaPend & ierEn[0] & ~selLine;
    selTo   = toPend & ierEn[0] & ~selLine & ~selRda;
    selThre = threPend & ierEn[1] & ~selLine & ~selRda & ~selTo;

    if (selLine)      shownId = ID_LINE;
    else if (selRda)  shownId = ID_RDA;
    else if (selTo)   shownId = ID_TIMEOUT;
    else if (selThre) shownId = ID_THRE;
    else              shownId = ID_NONE;

    iirValue = {IIR_FIFO_MARK, shownId};
  end

  // R2: a line-status read with no fresh error leaves the cause clear afterwards
  assert_line_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clrLine && !strobes.setLine) |=> !linePend);

  // R3: the data-available code is only ever shown with its enable set
  assert_rda_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (shownId == ID_RDA) |-> ierEn[0]);

  // R5: an empty receive queue leaves no timeout pending at the next edge
  assert_timeout_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rxCount == '0) |=> !toPend);

  // R6: any transmit-empty clear strobe removes the cause
  assert_thre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clrThre |=> !threPend);

  // R10: at most one cause is selected for display
  assert_single_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({selLine, selRda, selTo, selThre}));

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int ERR_W         = 4,
  parameter int CNT_W         = 5,
  parameter int TO_W          = 4,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       ierEn,
  input  logic [ERR_W-1:0] lineErr,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [1:0]       trigSel,
  input  logic [TO_W-1:0]  idleChars,
  input  logic             txEmpty,
  input  logic             iirRead,
  input  logic             lsrRead,
  input  logic             rbrRead,
  input  logic             thrWrite,
  output logic [7:0]       iirValue,
  output logic             irq
);

  irqStrobes_t strobes;
  irqId_t      shownId;

  uart_irq_ctrl #(.ERR_W(ERR_W)) ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lineErr    (lineErr),
    .txEmpty    (txEmpty),
    .threEnable (ierEn[1]),
    .iirRead    (iirRead),
    .lsrRead    (lsrRead),
    .rbrRead    (rbrRead),
    .thrWrite   (thrWrite),
    .shownId    (shownId),
    .strobes    (strobes)
  );

  uart_irq_dpath #(
    .CNT_W         (CNT_W),
    .TO_W          (TO_W),
    .TIMEOUT_CHARS (TIMEOUT_CHARS)
  ) dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .ierEn     (ierEn),
    .rxCount   (rxCount),
    .trigSel   (trigSel),
    .idleChars (idleChars),
    .shownId   (shownId),
    .iirValue  (iirValue)
  );

  assign irq = ~iirValue[0];

  // R9: with every enable cleared the request line stays low
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ierEn == 3'b000) |-> !irq);

  // R8: a raised request always comes with a non-idle code
  assert_irq_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (iirValue != 8'hC1));

endmodule

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] ierEn = 3'b000;
  logic [3:0] lineErr = 4'h0;
  logic [4:0] rxCount = 5'd0;
  logic [1:0] trigSel = 2'd0;
  logic [3:0] idleChars = 4'd0;
  logic       txEmpty = 1'b1;
  logic       iirRead = 1'b0;
  logic       lsrRead = 1'b0;
  logic       rbrRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic [7:0] iirValue;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_ident uut (
    .clk(clk), .rst_n(rst_n), .ierEn(ierEn), .lineErr(lineErr),
    .rxCount(rxCount), .trigSel(trigSel), .idleChars(idleChars),
    .txEmpty(txEmpty), .iirRead(iirRead), .lsrRead(lsrRead),
    .rbrRead(rbrRead), .thrWrite(thrWrite), .iirValue(iirValue), .irq(irq)
  );

  // Behavioural reference: one bit per cause plus the history it needs.
  bit mLine, mRda, mTo, mThre;
  logic [3:0] mErrPrev;
  bit mTxPrev, mEn1Prev;

  function automatic int levelOf(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic logic [7:0] expectedIir();
    if (ierEn[2] && mLine) return 8'hC6;
    if (ierEn[0] && mRda)  return 8'hC4;
    if (ierEn[0] && mTo)   return 8'hCC;
    if (ierEn[1] && mThre) return 8'hC2;
    return 8'hC1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mLine <= 0; mRda <= 0; mTo <= 0; mThre <= 0;
      mErrPrev <= 4'h0; mTxPrev <= 0; mEn1Prev <= 0;
    end else begin
      logic [7:0] now;
      bit risen, threSet, threClr;
      now = expectedIir();
      risen = ((lineErr & ~mErrPrev) != 4'h0);
      mLine <= risen || (mLine && !lsrRead);
      mRda <= (int'(rxCount) >= levelOf(trigSel));
      mTo <= (rxCount != 0) && !rbrRead && (mTo || int'(idleChars) >= 4);
      threSet = txEmpty && (!mTxPrev || (ierEn[1] && !mEn1Prev));
      threClr = thrWrite || !txEmpty || (iirRead && now == 8'hC2);
      mThre <= !threClr && (mThre || threSet);
      mErrPrev <= lineErr; mTxPrev <= txEmpty; mEn1Prev <= ierEn[1];
    end
  end

  function automatic string tagOf(input logic [7:0] v);
    case (v)
      8'hC6: return "R2";
      8'hC4: return "R3";
      8'hCC: return "R5";
      8'hC2: return "R6";
      default: return (ierEn == 0) ? "R9" : "R1";
    endcase
  endfunction

  task automatic compare(input logic [7:0] exp, input string tag);
    checks++;
    if (iirValue !== exp) begin
      failures++;
      $display("FAIL %s iir actual=%02h expected=%02h t=%0t", tag, iirValue, exp, $time);
    end
    checks++;
    if (irq !== (exp != 8'hC1)) begin
      failures++;
      $display("FAIL R8 irq actual=%0b expected=%0b t=%0t", irq, exp != 8'hC1, $time);
    end
  endtask

  // Every-cycle comparison against the reference model.
  always @(negedge clk) begin
    if (rst_n && !done) compare(expectedIir(), tagOf(expectedIir()));
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic pulseIir();  iirRead = 1;  tick(); iirRead = 0;  endtask
  task automatic pulseLsr();  lsrRead = 1;  tick(); lsrRead = 0;  endtask
  task automatic pulseRbr();  rbrRead = 1;  tick(); rbrRead = 0;  endtask
  task automatic pulseThr();  thrWrite = 1; tick(); thrWrite = 0; endtask

  initial begin
    repeat (3) tick();
    compare(8'hC1, "R1");              // R1: reset state
    rst_n = 1; tick(); tick();
    compare(8'hC1, "R1");              // R1: transmit-empty pending but masked

    // R6: enabling transmit-empty shows the pending cause
    ierEn = 3'b010; tick();
    compare(8'hC2, "R6");
    // R7: identification read while 0xC2 is shown clears it
    pulseIir();
    compare(8'hC1, "R7");
    // R6: txEmpty fall then rise re-arms; thrWrite clears
    txEmpty = 0; tick(); txEmpty = 1; tick();
    compare(8'hC2, "R6");
    pulseThr();
    compare(8'hC1, "R6");
    // R6: enable rising while empty re-arms
    ierEn = 3'b000; tick(); ierEn = 3'b010; tick();
    compare(8'hC2, "R6");

    // R3/R4: trigger levels
    ierEn = 3'b111;
    trigSel = 2'd1; rxCount = 5'd3; tick();
    compare(8'hC2, "R4");
    rxCount = 5'd4; tick();
    compare(8'hC4, "R4");
    pulseIir();                        // R7: read with 0xC4 shown clears nothing
    rxCount = 5'd3; tick();
    compare(8'hC2, "R7");
    trigSel = 2'd2; rxCount = 5'd7; tick();
    compare(8'hC2, "R4");
    rxCount = 5'd8; tick();
    compare(8'hC4, "R4");
    trigSel = 2'd3; rxCount = 5'd13; tick();
    compare(8'hC2, "R4");
    rxCount = 5'd14; tick();
    compare(8'hC4, "R3");
    trigSel = 2'd0; rxCount = 5'd1; tick();
    compare(8'hC4, "R4");
    rxCount = 5'd0; tick();
    compare(8'hC2, "R3");

    // R5: character timeout
    trigSel = 2'd3; rxCount = 5'd2; idleChars = 4'd3; tick();
    compare(8'hC2, "R5");
    idleChars = 4'd4; tick();
    compare(8'hCC, "R5");
    idleChars = 4'd0; pulseRbr();
    compare(8'hC2, "R5");
    idleChars = 4'd4; tick();
    compare(8'hCC, "R5");
    rxCount = 5'd0; idleChars = 4'd0; tick();
    compare(8'hC2, "R5");

    // R2/R10: line status beats data available
    rxCount = 5'd14; tick();
    compare(8'hC4, "R10");
    lineErr = 4'b0010; tick();
    compare(8'hC6, "R10");
    pulseLsr();
    compare(8'hC4, "R2");
    lineErr = 4'b0110; tick();
    compare(8'hC6, "R2");
    // R9: masking hides but keeps
    ierEn = 3'b000; #0.5;
    compare(8'hC1, "R9");
    tick();
    ierEn = 3'b111; #0.5;
    compare(8'hC6, "R9");
    pulseLsr();
    compare(8'hC4, "R2");
    lineErr = 4'h0; rxCount = 5'd0; tick();
    compare(8'hC2, "R10");
    pulseThr();
    compare(8'hC1, "R1");

    // Random phase, compared every cycle by the model.
    for (int i = 0; i < 3000; i++) begin
      ierEn     = 3'($urandom);
      if ($urandom % 4 == 0) lineErr = 4'($urandom);
      rxCount   = 5'($urandom % 17);
      trigSel   = 2'($urandom);
      idleChars = 4'($urandom % 16);
      txEmpty   = ($urandom % 3 != 0);
      iirRead   = ($urandom % 3 == 0);
      lsrRead   = ($urandom % 4 == 0);
      rbrRead   = ($urandom % 4 == 0);
      thrWrite  = ($urandom % 5 == 0);
      tick();
    end
    iirRead = 0; lsrRead = 0; rbrRead = 0; thrWrite = 0;
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule